// File: doc/BRIEF.md
# Next-Line Stream Prefetcher

This block sits beside a first-level data cache and turns demand misses and first touches of prefetched lines into short runs of next-line prefetch requests. Each cycle it scans a set of access ports (four by default). A port triggers the block when its access is valid and the access either misses or hits a line that still carries the prefetched mark. A trigger loads a stream with the access address and a depth: a short depth for a miss and a longer one for the first use of a prefetched line. The block then produces one candidate line per cycle until the depth is used up.

Each candidate goes through two checks before it becomes a request. The cache reports whether the candidate line is already present, and a recent-prefetch filter is looked up with the low bits of the candidate address. Only a candidate that passes both checks is offered on the valid/ready issue port. The block tells the filter to record a candidate only when the issue port accepts it. For each first-use hit, the block also pulses a clear-mark output on that port so the cache can drop the line's prefetched mark. The cache, the filter storage and the memory system are outside this block and appear only as ports.

The first candidate is produced in the same cycle as its trigger. After that the stream runs from registered state, advancing one line per cycle whether or not the candidate was issued.

Top module: `nl_stream_prefetcher`

## Requirements
- R1: While reset is asserted and after it is released with no access activity, probe_valid, pf_valid, filt_ins and all mark_clr bits stay low.
- R2: A port triggers only when acc_valid is high and either acc_miss or acc_pmark is high. A valid unmarked hit, or any access with acc_valid low, produces no candidate.
- R3: mark_clr[i] is high in the same cycle as a valid hit (acc_miss low) on port i with acc_pmark high. It is low for misses, for unmarked hits and for invalid accesses.
- R4: A miss trigger (this takes priority over acc_pmark on the same port) with address A gives exactly MISS_DEPTH candidates (default 1). The first is A+LINE_BYTES (LINE_BYTES defaults to 0x40), presented in the trigger cycle.
- R5: A first-use trigger with address A gives FU_DEPTH candidates (default 4) in consecutive cycles starting with the trigger cycle. These are A+0x40, A+0x80, A+0xC0 and A+0x100.
- R6: When several ports trigger in the same cycle, the highest-numbered triggering port alone sets the stream's address and depth.
- R7: pf_valid is high only when probe_valid is high, line_present is low and filt_hit is low. The stream still advances by one line when a candidate is suppressed.
- R8: filt_ins is high only when pf_valid and pf_ready are both high. filt_ins_key and probe_key equal the low KEY_W (16) bits of the candidate address.
- R9: A candidate offered with pf_ready low is dropped and not retried. The next cycle presents the following line.
- R10: A trigger that arrives while a stream is running replaces the stream's address and remaining depth in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | NPORT | Access present on port i this cycle |
| acc_miss | input | NPORT | Access on port i missed the cache |
| acc_pmark | input | NPORT | Line hit on port i carries the prefetched mark |
| acc_addr | input | NPORT*AW | Access addresses, port i at bits [i*AW +: AW] |
| mark_clr | output | NPORT | Clear the prefetched mark of the line hit on port i |
| probe_valid | output | 1 | A candidate is being evaluated this cycle |
| probe_addr | output | AW | Candidate line address, for the cache presence lookup |
| probe_key | output | KEY_W | Low bits of the candidate, for the filter lookup |
| line_present | input | 1 | The candidate line is already in the cache |
| filt_hit | input | 1 | The filter holds the candidate key |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | AW | Prefetch request address |
| pf_ready | input | 1 | The issue port accepts the request this cycle |
| filt_ins | output | 1 | Insert filt_ins_key into the filter |
| filt_ins_key | output | KEY_W | Key to insert into the filter |

## Verification
The hardest situation to reach from the ports is a stream whose state is changed partway through. This covers a new trigger that lands while earlier candidates are still pending, and a run where suppressed or rejected candidates are mixed with issued ones. The stimulus starts a first-use stream and then drives line_present, filt_hit and pf_ready low or high on chosen cycles of that same stream, so each gating path is seen with the stream still advancing. A second stream is cut off by a miss on another port one cycle after it starts. Same-cycle contention is covered by triggering several ports together with mixed miss and first-use kinds. A candidate whose address crosses a 64 KiB boundary checks that the filter key wraps.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
   typedef enum logic [1:0] {
      TRG_NONE  = 2'd0,
      TRG_MISS  = 2'd1,
      TRG_FIRST = 2'd2
   } trg_kind_e;
endpackage

// File: rtl/nlp_trigger_sel.sv
module nlp_trigger_sel
   import nlp_pkg::*;
#(
   parameter int NPORT = 4,
   parameter int AW    = 32
) (
   input  logic [NPORT-1:0]    acc_valid,
   input  logic [NPORT-1:0]    acc_miss,
   input  logic [NPORT-1:0]    acc_pmark,
   input  logic [NPORT*AW-1:0] acc_addr,
   output trg_kind_e           trg_kind,
   output logic [AW-1:0]       trg_addr,
   output logic [NPORT-1:0]    mark_clr
);
   // later ports override earlier ones: the last match in the scan wins
   always_comb begin
      trg_kind = TRG_NONE;
      trg_addr = '0;
      for (int i = 0; i < NPORT; i++) begin
         if (acc_valid[i] && acc_miss[i]) begin
            trg_kind = TRG_MISS;
            trg_addr = acc_addr[i*AW +: AW];
         end else if (acc_valid[i] && acc_pmark[i]) begin
            trg_kind = TRG_FIRST;
            trg_addr = acc_addr[i*AW +: AW];
         end
      end
   end

   for (genvar g = 0; g < NPORT; g++) begin : g_clr
      assign mark_clr[g] = acc_valid[g] & ~acc_miss[g] & acc_pmark[g];
   end
endmodule

// File: rtl/nlp_stream_ctl.sv
module nlp_stream_ctl
   import nlp_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MISS_DEPTH = 1,
   parameter int FU_DEPTH   = 4,
   parameter int CNT_W      = 3,
   parameter bit ALIGN_BASE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  trg_kind_e     trg_kind,
   input  logic [AW-1:0] trg_addr,
   output logic          cand_valid,
   output logic [AW-1:0] cand_addr
);
   localparam logic [AW-1:0]    LINE_STEP = AW'(LINE_BYTES);
   localparam logic [AW-1:0]    LINE_MASK = AW'(LINE_BYTES - 1);
   localparam logic [CNT_W-1:0] MISS_CNT  = CNT_W'(MISS_DEPTH);
   localparam logic [CNT_W-1:0] FU_CNT    = CNT_W'(FU_DEPTH);

   logic [AW-1:0]    base_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    start_addr;
   logic [AW-1:0]    eff_base;
   logic [CNT_W-1:0] eff_cnt;

   if (ALIGN_BASE) begin : g_align
      assign start_addr = trg_addr & ~LINE_MASK;
   end else begin : g_raw
      assign start_addr = trg_addr;
   end

   always_comb begin
      unique case (trg_kind)
         TRG_MISS: begin
            eff_base = start_addr;
            eff_cnt  = MISS_CNT;
         end
         TRG_FIRST: begin
            eff_base = start_addr;
            eff_cnt  = FU_CNT;
         end
         default: begin
            eff_base = base_q;
            eff_cnt  = cnt_q;
         end
      endcase
   end

   assign cand_valid = (eff_cnt != '0);
   assign cand_addr  = eff_base + LINE_STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (cand_valid) begin
         base_q <= cand_addr;
         cnt_q  <= eff_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/nlp_issue_gate.sv
module nlp_issue_gate #(
   parameter int AW    = 32,
   parameter int KEY_W = 16
) (
   input  logic             cand_valid,
   input  logic [AW-1:0]    cand_addr,
   input  logic             line_present,
   input  logic             filt_hit,
   input  logic             pf_ready,
   output logic [KEY_W-1:0] probe_key,
   output logic             pf_valid,
   output logic [AW-1:0]    pf_addr,
   output logic             filt_ins,
   output logic [KEY_W-1:0] filt_ins_key
);
   assign probe_key    = cand_addr[KEY_W-1:0];
   assign pf_valid     = cand_valid & ~line_present & ~filt_hit;
   assign pf_addr      = cand_addr;
   assign filt_ins     = pf_valid & pf_ready;
   assign filt_ins_key = probe_key;
endmodule

// File: rtl/nl_stream_prefetcher.sv
module nl_stream_prefetcher
   import nlp_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MISS_DEPTH = 1,
   parameter int FU_DEPTH   = 4,
   parameter int KEY_W      = 16,
   parameter bit ALIGN_BASE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    acc_valid,
   input  logic [NPORT-1:0]    acc_miss,
   input  logic [NPORT-1:0]    acc_pmark,
   input  logic [NPORT*AW-1:0] acc_addr,
   output logic [NPORT-1:0]    mark_clr,
   output logic                probe_valid,
   output logic [AW-1:0]       probe_addr,
   output logic [KEY_W-1:0]    probe_key,
   input  logic                line_present,
   input  logic                filt_hit,
   output logic                pf_valid,
   output logic [AW-1:0]       pf_addr,
   input  logic                pf_ready,
   output logic                filt_ins,
   output logic [KEY_W-1:0]    filt_ins_key
);
   localparam int MAX_DEPTH = (MISS_DEPTH > FU_DEPTH) ? MISS_DEPTH : FU_DEPTH;
   localparam int CNT_W     = $clog2(MAX_DEPTH + 1);

   if (NPORT < 1) begin : g_bad_nport
      $error("NPORT must be at least 1");
   end
   if ((LINE_BYTES < 1) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((KEY_W < 1) || (KEY_W > AW)) begin : g_bad_key
      $error("KEY_W must lie in 1..AW");
   end
   if ((MISS_DEPTH < 1) || (FU_DEPTH < 1)) begin : g_bad_depth
      $error("stream depths must be positive");
   end

   trg_kind_e     trg_kind;
   logic [AW-1:0] trg_addr;

   nlp_trigger_sel #(.NPORT(NPORT), .AW(AW)) u_sel (
      .acc_valid (acc_valid),
      .acc_miss  (acc_miss),
      .acc_pmark (acc_pmark),
      .acc_addr  (acc_addr),
      .trg_kind  (trg_kind),
      .trg_addr  (trg_addr),
      .mark_clr  (mark_clr)
   );

   nlp_stream_ctl #(
      .AW(AW), .LINE_BYTES(LINE_BYTES), .MISS_DEPTH(MISS_DEPTH),
      .FU_DEPTH(FU_DEPTH), .CNT_W(CNT_W), .ALIGN_BASE(ALIGN_BASE)
   ) u_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .trg_kind   (trg_kind),
      .trg_addr   (trg_addr),
      .cand_valid (probe_valid),
      .cand_addr  (probe_addr)
   );

   nlp_issue_gate #(.AW(AW), .KEY_W(KEY_W)) u_gate (
      .cand_valid   (probe_valid),
      .cand_addr    (probe_addr),
      .line_present (line_present),
      .filt_hit     (filt_hit),
      .pf_ready     (pf_ready),
      .probe_key    (probe_key),
      .pf_valid     (pf_valid),
      .pf_addr      (pf_addr),
      .filt_ins     (filt_ins),
      .filt_ins_key (filt_ins_key)
   );
endmodule

// File: rtl/nlp_chk.sv
module nlp_chk
   import nlp_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MISS_DEPTH = 1,
   parameter int KEY_W      = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPORT-1:0] acc_valid,
   input logic [NPORT-1:0] acc_miss,
   input logic [NPORT-1:0] acc_pmark,
   input logic [NPORT-1:0] mark_clr,
   input trg_kind_e        trg_kind,
   input logic             probe_valid,
   input logic [AW-1:0]    probe_addr,
   input logic [KEY_W-1:0] probe_key,
   input logic             line_present,
   input logic             filt_hit,
   input logic             pf_valid,
   input logic             filt_ins,
   input logic [KEY_W-1:0] filt_ins_key
);
   logic any_trig;
   assign any_trig = |(acc_valid & (acc_miss | acc_pmark));

   // R3
   clr_starts_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_clr != '0) |-> (probe_valid && ((mark_clr & acc_miss) == '0)));

   // R7
   issue_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> (probe_valid && !line_present && !filt_hit));

   // R8
   insert_matches_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filt_ins |-> (pf_valid && filt_ins_key == probe_key));

   // R9
   stream_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_trig && probe_valid && $past(probe_valid))
         |-> (probe_addr == $past(probe_addr) + AW'(LINE_BYTES)));

   // R4
   miss_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (MISS_DEPTH == 1 && trg_kind == TRG_MISS) |=> (any_trig || !probe_valid));

   // R2
   idle_without_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_trig && !$past(probe_valid)) |-> !probe_valid);
endmodule

bind nl_stream_prefetcher nlp_chk #(
   .NPORT(NPORT), .AW(AW), .LINE_BYTES(LINE_BYTES),
   .MISS_DEPTH(MISS_DEPTH), .KEY_W(KEY_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_miss     (acc_miss),
   .acc_pmark    (acc_pmark),
   .mark_clr     (mark_clr),
   .trg_kind     (trg_kind),
   .probe_valid  (probe_valid),
   .probe_addr   (probe_addr),
   .probe_key    (probe_key),
   .line_present (line_present),
   .filt_hit     (filt_hit),
   .pf_valid     (pf_valid),
   .filt_ins     (filt_ins),
   .filt_ins_key (filt_ins_key)
);

// File: tb/test_nl_stream_prefetcher.sv
module test_nl_stream_prefetcher;
   localparam int NP = 4;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   acc_valid = '0, acc_miss = '0, acc_pmark = '0;
   logic [NP*AW-1:0] acc_addr = '0;
   logic [NP-1:0]   mark_clr;
   logic            probe_valid, pf_valid, filt_ins;
   logic [AW-1:0]   probe_addr, pf_addr;
   logic [15:0]     probe_key, filt_ins_key;
   logic            line_present = 1'b0, filt_hit = 1'b0, pf_ready = 1'b1;

   always #5 clk = ~clk;

   nl_stream_prefetcher i_nl_stream_prefetcher (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss),
      .acc_pmark(acc_pmark), .acc_addr(acc_addr), .mark_clr(mark_clr),
      .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_key(probe_key),
      .line_present(line_present), .filt_hit(filt_hit), .pf_valid(pf_valid),
      .pf_addr(pf_addr), .pf_ready(pf_ready), .filt_ins(filt_ins),
      .filt_ins_key(filt_ins_key)
   );

   typedef struct {
      logic          pv;
      logic [AW-1:0] addr;
      logic          pf;
      logic          ins;
      logic [NP-1:0] clr;
      string         tag;
   } exp_t;

   exp_t expq[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // staged access stimulus for the next step
   logic [NP-1:0]    s_v = '0, s_m = '0, s_k = '0;
   logic [NP*AW-1:0] s_a = '0;

   task automatic acc(input int p, input bit miss, input bit mark, input logic [AW-1:0] a);
      s_v[p] = 1'b1;
      s_m[p] = miss;
      s_k[p] = mark;
      s_a[p*AW +: AW] = a;
   endtask

   task automatic acc_invalid(input int p, input logic [AW-1:0] a);
      s_v[p] = 1'b0;
      s_m[p] = 1'b1;
      s_k[p] = 1'b1;
      s_a[p*AW +: AW] = a;
   endtask

   // driver: apply one cycle of stimulus and push the expected result
   task automatic step(input bit pres, input bit fh, input bit rdy, input bit ev,
                       input logic [AW-1:0] ea, input logic [NP-1:0] eclr,
                       input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid = s_v; acc_miss = s_m; acc_pmark = s_k; acc_addr = s_a;
      line_present = pres; filt_hit = fh; pf_ready = rdy;
      s_v = '0; s_m = '0; s_k = '0; s_a = '0;
      e.pv  = ev;
      e.addr = ea;
      e.pf  = ev && !pres && !fh;
      e.ins = e.pf && rdy;
      e.clr = eclr;
      e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // monitor: compare the design's outputs late in each cycle
   always begin
      @(negedge clk);
      #4;
      if (expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         chk(e.tag, "probe_valid", 64'(probe_valid), 64'(e.pv));
         chk(e.tag, "mark_clr", 64'(mark_clr), 64'(e.clr));
         chk(e.tag, "pf_valid", 64'(pf_valid), 64'(e.pf));
         chk(e.tag, "filt_ins", 64'(filt_ins), 64'(e.ins));
         if (e.pv) begin
            chk(e.tag, "probe_addr", 64'(probe_addr), 64'(e.addr));
            chk(e.tag, "probe_key", 64'(probe_key), 64'(e.addr[15:0]));
         end
         if (e.pf) chk(e.tag, "pf_addr", 64'(pf_addr), 64'(e.addr));
         if (e.ins) chk(e.tag, "filt_ins_key", 64'(filt_ins_key), 64'(e.addr[15:0]));
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: quiet during reset
      step(0, 0, 1, 0, '0, 4'b0000, "R1");
      step(0, 0, 1, 0, '0, 4'b0000, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, 1, 0, '0, 4'b0000, "R1");

      // R4: miss gives one line, first candidate in the trigger cycle
      acc(0, 1, 0, 32'h0000_1000);
      step(0, 0, 1, 1, 32'h0000_1040, 4'b0000, "R4");
      step(0, 0, 1, 0, '0, 4'b0000, "R4");

      // R2: unmarked hit and invalid access do not trigger
      acc(1, 0, 0, 32'h0000_2000);
      acc_invalid(2, 32'h0000_2400);
      step(0, 0, 1, 0, '0, 4'b0000, "R2");

      // R3 R5: first use on port 2 gives four lines
      acc(2, 0, 1, 32'h0000_3000);
      step(0, 0, 1, 1, 32'h0000_3040, 4'b0100, "R5");
      step(0, 0, 1, 1, 32'h0000_3080, 4'b0000, "R5");
      step(0, 0, 1, 1, 32'h0000_30C0, 4'b0000, "R5");
      step(0, 0, 1, 1, 32'h0000_3100, 4'b0000, "R5");
      step(0, 0, 1, 0, '0, 4'b0000, "R5");

      // R4 miss takes priority over the mark; no clear on a miss (R3)
      acc(1, 1, 1, 32'h0000_9000);
      step(0, 0, 1, 1, 32'h0000_9040, 4'b0000, "R3");
      step(0, 0, 1, 0, '0, 4'b0000, "R4");

      // R6: port 3 first use overrides port 1 miss
      acc(1, 1, 0, 32'h0000_4000);
      acc(3, 0, 1, 32'h0000_5000);
      step(0, 0, 1, 1, 32'h0000_5040, 4'b1000, "R6");
      step(0, 0, 1, 1, 32'h0000_5080, 4'b0000, "R6");
      step(0, 0, 1, 1, 32'h0000_50C0, 4'b0000, "R6");
      step(0, 0, 1, 1, 32'h0000_5100, 4'b0000, "R6");
      step(0, 0, 1, 0, '0, 4'b0000, "R6");

      // R6: port 2 miss overrides port 0 first use
      acc(0, 0, 1, 32'h0000_A000);
      acc(2, 1, 0, 32'h0000_B000);
      step(0, 0, 1, 1, 32'h0000_B040, 4'b0001, "R6");
      step(0, 0, 1, 0, '0, 4'b0000, "R6");

      // R7 R9: gating and rejection while the stream keeps advancing
      acc(0, 0, 1, 32'h0000_6000);
      step(1, 0, 1, 1, 32'h0000_6040, 4'b0001, "R7");
      step(0, 1, 1, 1, 32'h0000_6080, 4'b0000, "R7");
      step(0, 0, 0, 1, 32'h0000_60C0, 4'b0000, "R9");
      step(0, 0, 1, 1, 32'h0000_6100, 4'b0000, "R9");
      step(0, 0, 1, 0, '0, 4'b0000, "R7");

      // R10: a miss mid-stream restarts with new address and depth
      acc(1, 0, 1, 32'h0000_7000);
      step(0, 0, 1, 1, 32'h0000_7040, 4'b0010, "R10");
      acc(3, 1, 0, 32'h0000_8000);
      step(0, 0, 1, 1, 32'h0000_8040, 4'b0000, "R10");
      step(0, 0, 1, 0, '0, 4'b0000, "R10");

      // R8: key wraps at the low 16 bits
      acc(0, 1, 0, 32'h1234_FFC0);
      step(0, 0, 1, 1, 32'h1235_0000, 4'b0000, "R8");
      step(0, 0, 1, 0, '0, 4'b0000, "R8");

      @(negedge clk);
      @(negedge clk);
      #6;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule